// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block holds two independent timer/counter channels, numbered 0 and 1. Each channel owns a 16-bit count split into a low byte and a high byte. It counts either ticks of an internal clock or falling edges on its own external count pin. Counting can also be made to wait for a level on an external gate pin. A shared mode register picks a counting format for each channel: 13-bit, 16-bit, 8-bit with automatic reload, or a split format. In the split format channel 0 becomes two separate 8-bit counters.

A free-running divider gives an internal tick once every DIV system clocks (12 by default). Through a speed-select register, each channel can instead take a tick on every system clock; the counting formats behave the same either way. Software uses a byte-wide register port. A write is a single cycle with `reg_wr_en` high. A read is combinational from `reg_addr`. There is no handshake and no back-pressure on this port: every write is taken in the cycle it is presented.

Top module: `dual_tmr_unit`

## Requirements
- R1: After reset, every register reads zero: the mode and control registers, all four count bytes, and the speed select. Both channels therefore start on the divided tick.
- R2: Register addresses: 0x88 control, 0x89 mode, 0x8A/0x8B low byte of channel 0/1, 0x8C/0x8D high byte of channel 0/1, 0x8E speed select. Mode bits [7:4] configure channel 1 and bits [3:0] configure channel 0, each nibble being {gate, external, fmt[1:0]}. Control bits: [0] run0, [1] flag0, [2] run1, [3] flag1. Speed-select bit i set means channel i ticks every clock. Written values read back unchanged.
- R3: With external=0 and speed-select bit 0, a running channel advances by exactly one for every DIV system clocks.
- R4: With speed-select bit 1, a running timer channel advances by one on every system clock.
- R5: With external=1, a running channel advances by exactly one for each high-to-low transition of its count pin, however long the pin stays low.
- R6: A channel counts only while its run bit is 1 and, when gate=1, only while its gate pin is high. Otherwise its count is held.
- R7: fmt=00 counts the 13-bit value {high byte, low byte[4:0]}. Low byte bits [7:5] keep the value they were written with. Going from 0x1FFF to zero sets the flag.
- R8: fmt=01 counts the full 16-bit value. Going from 0xFFFF to zero sets the flag.
- R9: fmt=10 counts the low byte only. When the low byte would pass 0xFF it is loaded from the high byte and the flag is set; the high byte is left unchanged.
- R10: When channel 0 has fmt=11, its low byte is an 8-bit counter under run0, gate0 and flag0. Its high byte is an 8-bit timer on channel 0's tick, runs while run1 is set, and sets flag1 when it wraps from 0xFF.
- R11: Channel 1 with fmt=11 holds its count. While channel 0 has fmt=11, channel 1 still counts, but its wrap no longer sets flag1.
- R12: A flag set by a wrap stays at 1 until a control-register write puts 0 in that bit. A control write loads all four bits as written, but a wrap in the same cycle still sets its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wr_en | input | 1 | Write strobe, one write per cycle it is high |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Combinational read data for `reg_addr` |
| t0_cnt_pin | input | 1 | External count input of channel 0 |
| t1_cnt_pin | input | 1 | External count input of channel 1 |
| t0_gate_pin | input | 1 | Gate level input of channel 0 |
| t1_gate_pin | input | 1 | Gate level input of channel 1 |

## Verification
The bound checker watches four things on every cycle:
- a stopped channel 0 holding its low byte;
- channel 1 holding its count while it is in the split format;
- flags that stay set until a control write, and that are always raised by a wrap;
- the reload landing in the low byte, and the divided tick coming every DIV clocks.

The exact count after a run depends on the counting format, the start value and the run length, so only the bench's scenarios can show it. The same holds for:
- the number of increments from a train of pin pulses;
- how the gate pin acts;
- the way split mode passes flag1 from channel 1 to the high byte of channel 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 8;
  localparam int PRE_W  = 5;
  localparam int CFG_W  = 4;
  localparam int NCH    = 2;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 8'h88;
  localparam logic [ADDR_W-1:0] A_MODE = 8'h89;
  localparam logic [ADDR_W-1:0] A_LO0  = 8'h8A;
  localparam logic [ADDR_W-1:0] A_HI0  = 8'h8C;
  localparam logic [ADDR_W-1:0] A_SEL  = 8'h8E;

  typedef enum logic [1:0] {
    FMT_13     = 2'b00,
    FMT_16     = 2'b01,
    FMT_RELOAD = 2'b10,
    FMT_SPLIT  = 2'b11
  } fmt_e;

  typedef struct packed {
    logic gate;
    logic ext;
    fmt_e fmt;
  } chan_cfg_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/tmr_fall_det.sv
module tmr_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic samp_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      samp_q <= pin;
      prev_q <= samp_q;
    end
  end

  assign fall = prev_q & ~samp_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter bit HAS_SPLIT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmt_e             fmt,
  input  logic             step_main,
  input  logic             step_split,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] lo_q,
  output logic [CNT_W-1:0] hi_q,
  output logic             ovf_main,
  output logic             ovf_split
);
  localparam int W13 = CNT_W + PRE_W;
  localparam int W16 = 2 * CNT_W;
  localparam logic [CNT_W-1:0] BYTE_MAX = '1;

  logic             busy, go, go_s;
  logic [W13:0]     sum13;
  logic [W16:0]     sum16;
  logic [CNT_W-1:0] lo_n, hi_n;

  assign busy  = wr_lo | wr_hi;
  assign go    = step_main & ~busy;
  assign go_s  = step_split & ~busy;
  assign sum13 = {1'b0, hi_q, lo_q[PRE_W-1:0]} + (W13 + 1)'(1);
  assign sum16 = {1'b0, hi_q, lo_q} + (W16 + 1)'(1);

  always_comb begin
    lo_n      = lo_q;
    hi_n      = hi_q;
    ovf_main  = 1'b0;
    ovf_split = 1'b0;
    unique case (fmt)
      FMT_13: if (go) begin
        hi_n              = sum13[W13-1:PRE_W];
        lo_n[PRE_W-1:0]   = sum13[PRE_W-1:0];
        ovf_main          = sum13[W13];
      end
      FMT_16: if (go) begin
        {hi_n, lo_n} = sum16[W16-1:0];
        ovf_main     = sum16[W16];
      end
      FMT_RELOAD: if (go) begin
        if (lo_q == BYTE_MAX) begin
          lo_n     = hi_q;
          ovf_main = 1'b1;
        end else begin
          lo_n = lo_q + 1'b1;
        end
      end
      FMT_SPLIT: if (HAS_SPLIT) begin
        if (go) begin
          lo_n     = lo_q + 1'b1;
          ovf_main = (lo_q == BYTE_MAX);
        end
        if (go_s) begin
          hi_n      = hi_q + 1'b1;
          ovf_split = (hi_q == BYTE_MAX);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= wr_lo ? wdata : lo_n;
      hi_q <= wr_hi ? wdata : hi_n;
    end
  end
endmodule

// File: rtl/dual_tmr_unit.sv
module dual_tmr_unit
  import tmr_pkg::*;
#(
  parameter int DIV = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [CNT_W-1:0]  reg_wr_data,
  output logic [CNT_W-1:0]  reg_rd_data,
  input  logic              t0_cnt_pin,
  input  logic              t1_cnt_pin,
  input  logic              t0_gate_pin,
  input  logic              t1_gate_pin
);
  localparam int CTRL_W = 2 * NCH;

  logic [NCH*CFG_W-1:0]      mode_reg;
  logic [CTRL_W-1:0]         ctrl_reg;
  logic [NCH-1:0]            sel_reg;
  logic                      tick12;
  logic [NCH-1:0]            cnt_pin, gate_pin, fall, tick_ch, run_bit;
  logic [NCH-1:0]            step_main, step_split, wr_lo, wr_hi;
  logic [NCH-1:0]            ovf_main, ovf_split, flag_set;
  logic [NCH-1:0][CNT_W-1:0] lo_q, hi_q;
  logic                      split0, wr_ctrl, wr_mode, wr_sel;
  logic [CTRL_W-1:0]         ctrl_base, flag_mask;

  assign cnt_pin  = {t1_cnt_pin, t0_cnt_pin};
  assign gate_pin = {t1_gate_pin, t0_gate_pin};
  assign wr_ctrl  = reg_wr_en && (reg_addr == A_CTRL);
  assign wr_mode  = reg_wr_en && (reg_addr == A_MODE);
  assign wr_sel   = reg_wr_en && (reg_addr == A_SEL);

  tmr_prescale #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick12)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_cfg_t cfg;
    logic      evt;

    assign cfg        = chan_cfg_t'(mode_reg[i*CFG_W +: CFG_W]);
    assign run_bit[i] = ctrl_reg[2*i];
    assign tick_ch[i] = sel_reg[i] | tick12;
    assign evt        = cfg.ext ? fall[i] : tick_ch[i];
    assign step_main[i] = run_bit[i] & (~cfg.gate | gate_pin[i]) & evt;
    assign wr_lo[i]   = reg_wr_en && (reg_addr == A_LO0 + ADDR_W'(i));
    assign wr_hi[i]   = reg_wr_en && (reg_addr == A_HI0 + ADDR_W'(i));

    if (i == 0) begin : g_split_src
      assign step_split[i] = ctrl_reg[2] & tick_ch[0];
    end else begin : g_no_split
      assign step_split[i] = 1'b0;
    end

    tmr_fall_det u_fall (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (cnt_pin[i]),
      .fall (fall[i])
    );

    tmr_channel #(.HAS_SPLIT(i == 0)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .fmt       (cfg.fmt),
      .step_main (step_main[i]),
      .step_split(step_split[i]),
      .wr_lo     (wr_lo[i]),
      .wr_hi     (wr_hi[i]),
      .wdata     (reg_wr_data),
      .lo_q      (lo_q[i]),
      .hi_q      (hi_q[i]),
      .ovf_main  (ovf_main[i]),
      .ovf_split (ovf_split[i])
    );
  end

  assign split0      = (mode_reg[1:0] == FMT_SPLIT);
  assign flag_set[0] = ovf_main[0];
  assign flag_set[1] = split0 ? ovf_split[0] : ovf_main[1];

  always_comb begin
    flag_mask = '0;
    for (int i = 0; i < NCH; i++) flag_mask[2*i+1] = flag_set[i];
  end

  assign ctrl_base = wr_ctrl ? reg_wr_data[CTRL_W-1:0] : ctrl_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_reg <= '0;
      ctrl_reg <= '0;
      sel_reg  <= '0;
    end else begin
      ctrl_reg <= ctrl_base | flag_mask;
      if (wr_mode) mode_reg <= reg_wr_data[NCH*CFG_W-1:0];
      if (wr_sel)  sel_reg  <= reg_wr_data[NCH-1:0];
    end
  end

  always_comb begin
    reg_rd_data = '0;
    unique case (reg_addr)
      A_CTRL:                reg_rd_data = CNT_W'(ctrl_reg);
      A_MODE:                reg_rd_data = CNT_W'(mode_reg);
      A_SEL:                 reg_rd_data = CNT_W'(sel_reg);
      A_LO0:                 reg_rd_data = lo_q[0];
      A_LO0 + ADDR_W'(1):    reg_rd_data = lo_q[1];
      A_HI0:                 reg_rd_data = hi_q[0];
      A_HI0 + ADDR_W'(1):    reg_rd_data = hi_q[1];
      default:               reg_rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dual_tmr_unit_chk.sv
module dual_tmr_unit_chk
  import tmr_pkg::*;
#(
  parameter int DIV = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        mode_reg,
  input logic [3:0]        ctrl_reg,
  input logic [7:0]        tl0,
  input logic [7:0]        th0,
  input logic [7:0]        tl1,
  input logic [7:0]        th1,
  input logic              tick12,
  input logic              ovf_lo0
);
  logic [15:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (tick12) gap_q <= '0;
    else             gap_q <= gap_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick12 |-> (gap_q == 16'(DIV - 1)));                                  // R3

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_reg[0] && !wr_en) |=> $stable(tl0));                           // R6

  AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_reg[1:0] == 2'b10 && ovf_lo0 && !wr_en) |=> (tl0 == th0));      // R9

  AST_T1_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_reg[5:4] == 2'b11 && !wr_en) |=> $stable({th1, tl1}));          // R11

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_reg[1] && !(wr_en && addr == A_CTRL)) |=> ctrl_reg[1]);         // R12

  AST_FLAG_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_lo0 |=> ctrl_reg[1]);                                             // R12
endmodule

bind dual_tmr_unit dual_tmr_unit_chk #(.DIV(DIV)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (reg_wr_en),
  .addr    (reg_addr),
  .mode_reg(mode_reg),
  .ctrl_reg(ctrl_reg),
  .tl0     (lo_q[0]),
  .th0     (hi_q[0]),
  .tl1     (lo_q[1]),
  .th1     (hi_q[1]),
  .tick12  (tick12),
  .ovf_lo0 (ovf_main[0])
);

// File: tb/dual_tmr_unit_test.sv
module dual_tmr_unit_test;
  localparam int DIV = 12;
  localparam logic [7:0] CTRL = 8'h88, MODE = 8'h89, LO0 = 8'h8A, HI0 = 8'h8C, SEL = 8'h8E;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic [7:0] reg_rd_data;
  logic       t0_cnt_pin = 1'b1, t1_cnt_pin = 1'b1;
  logic       t0_gate_pin = 1'b0, t1_gate_pin = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_tmr_unit #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .t0_cnt_pin(t0_cnt_pin), .t1_cnt_pin(t1_cnt_pin),
    .t0_gate_pin(t0_gate_pin), .t1_gate_pin(t1_gate_pin)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rd_data;
  endtask

  // Sets the run bits in mask, lets exactly k rising edges count, then clears them keeping flags.
  task automatic run_for(input int k, input logic [7:0] mask);
    logic [7:0] cur;
    reg_wr(CTRL, mask);
    repeat (k - 2) @(negedge clk);
    @(negedge clk);
    reg_addr = CTRL;
    #1 cur = reg_rd_data;
    reg_wr_data = cur & ~mask; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // Arithmetic model: {flag, high, low} after k increments in format m.
  function automatic logic [16:0] model(input int m, input logic [15:0] v0, input int k);
    logic [15:0] v = v0;
    logic        f = 1'b0;
    logic [12:0] c;
    for (int n = 0; n < k; n++) begin
      case (m)
        0: begin
          c = {v[15:8], v[4:0]};
          if (c == 13'h1FFF) f = 1'b1;
          c = c + 13'd1;
          v = {c[12:5], v[7:5], c[4:0]};
        end
        1: begin
          if (v == 16'hFFFF) f = 1'b1;
          v = v + 16'd1;
        end
        default: begin
          if (v[7:0] == 8'hFF) begin f = 1'b1; v[7:0] = v[15:8]; end
          else v[7:0] = v[7:0] + 8'd1;
        end
      endcase
    end
    return {f, v};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lo, hi, ct, rd;
    logic [16:0] exp;
    logic [15:0] st;
    int ks [3] = '{2, 9, 33};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values of every register
    foreach (ks[q]) ;
    for (int a = 8'h88; a <= 8'h8E; a++) begin
      reg_rd(8'(a), rd);
      chk("R1 reset value", {8'h00, rd}, 16'h0000);
    end

    // R2: readback of written registers
    reg_wr(MODE, 8'hA5); reg_rd(MODE, rd); chk("R2 mode readback", {8'h0, rd}, 16'h00A5);
    reg_wr(SEL, 8'h02);  reg_rd(SEL, rd);  chk("R2 select readback", {8'h0, rd}, 16'h0002);
    reg_wr(MODE, 8'h00);
    for (int a = 0; a < 4; a++) begin
      reg_wr(8'h8A + 8'(a), 8'h31 + 8'(a * 17));
      reg_rd(8'h8A + 8'(a), rd);
      chk("R2 count byte readback", {8'h0, rd}, {8'h0, 8'h31 + 8'(a * 17)});
    end
    reg_wr(CTRL, 8'h0A); reg_rd(CTRL, rd); chk("R2 R12 flag write loads", {8'h0, rd}, 16'h000A);

    // R3: divided tick, window of 12*M clocks
    for (int ch = 0; ch < 2; ch++) begin
      reg_wr(SEL, 8'h00);
      reg_wr(MODE, 8'h11);
      reg_wr(CTRL, 8'h00);
      reg_wr(LO0 + 8'(ch), 8'h00); reg_wr(HI0 + 8'(ch), 8'h00);
      run_for(12 * (5 + ch * 2), ch ? 8'h04 : 8'h01);
      reg_rd(LO0 + 8'(ch), lo); reg_rd(HI0 + 8'(ch), hi);
      chk("R3 divided tick count", {hi, lo}, 16'(5 + ch * 2));
    end

    // R4 R7 R8 R9: sweep of formats, start values and run lengths on both channels
    reg_wr(SEL, 8'h03);
    for (int ch = 0; ch < 2; ch++)
      for (int m = 0; m < 3; m++)
        for (int j = 0; j < 4; j++)
          for (int kk = 0; kk < 3; kk++) begin
            st = 16'hFFFF - 16'(j * 16'h0107);
            reg_wr(MODE, ch ? {2'b00, 2'(m), 4'h0} : {4'h0, 2'b00, 2'(m)});
            reg_wr(CTRL, 8'h00);
            reg_wr(LO0 + 8'(ch), st[7:0]); reg_wr(HI0 + 8'(ch), st[15:8]);
            run_for(ks[kk], ch ? 8'h04 : 8'h01);
            reg_rd(LO0 + 8'(ch), lo); reg_rd(HI0 + 8'(ch), hi); reg_rd(CTRL, ct);
            exp = model(m, st, ks[kk]);
            if (m == 0)      chk("R7 R4 13-bit count", {hi, lo}, exp[15:0]);
            else if (m == 1) chk("R8 R4 16-bit count", {hi, lo}, exp[15:0]);
            else             chk("R9 R4 reload count", {hi, lo}, exp[15:0]);
            chk("R12 wrap flag", {15'h0, ct[2*ch+1]}, {15'h0, exp[16]});
          end

    // R5: external falling edges
    reg_wr(SEL, 8'h00);
    reg_wr(MODE, 8'h55);
    reg_wr(CTRL, 8'h00);
    for (int a = 0; a < 4; a++) reg_wr(LO0 + 8'(a), 8'h00);
    reg_wr(CTRL, 8'h05);
    for (int p = 0; p < 7; p++) begin
      @(negedge clk); t0_cnt_pin = 1'b0; if (p < 4) t1_cnt_pin = 1'b0;
      repeat (3 + p) @(negedge clk);
      t0_cnt_pin = 1'b1; t1_cnt_pin = 1'b1;
      repeat (3) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    reg_wr(CTRL, 8'h00);
    reg_rd(LO0, lo); chk("R5 edge count ch0", {8'h0, lo}, 16'd7);
    reg_rd(8'h8B, lo); chk("R5 edge count ch1", {8'h0, lo}, 16'd4);

    // R6: run bit clear and gate pin low both hold the count
    reg_wr(SEL, 8'h03);
    reg_wr(MODE, 8'h99);
    for (int a = 0; a < 4; a++) reg_wr(LO0 + 8'(a), 8'h00);
    repeat (20) @(negedge clk);
    reg_rd(LO0, lo); chk("R6 run clear holds", {8'h0, lo}, 16'd0);
    t0_gate_pin = 1'b0; t1_gate_pin = 1'b1;
    run_for(10, 8'h05);
    reg_rd(LO0, lo); chk("R6 gate low holds", {8'h0, lo}, 16'd0);
    reg_rd(8'h8B, lo); chk("R6 gate high counts", {8'h0, lo}, 16'd10);
    t0_gate_pin = 1'b1;
    run_for(10, 8'h01);
    reg_rd(LO0, lo); chk("R6 gate raised counts", {8'h0, lo}, 16'd10);

    // R10 R11: channel 0 split, channel 1 wrap must not set flag1
    for (int s = 0; s < 2; s++) begin
      reg_wr(MODE, 8'h13);
      reg_wr(CTRL, 8'h00);
      reg_wr(LO0, 8'hF8); reg_wr(HI0, s ? 8'hFA : 8'h10);
      reg_wr(8'h8B, 8'hFE); reg_wr(8'h8D, 8'hFF);
      run_for(12, 8'h05);
      reg_rd(LO0, lo); chk("R10 split low byte", {8'h0, lo}, 16'h0004);
      reg_rd(HI0, hi); chk("R10 split high byte", {8'h0, hi}, s ? 16'h0006 : 16'h001C);
      reg_rd(CTRL, ct);
      chk("R10 split flag0", {15'h0, ct[1]}, 16'd1);
      chk("R10 R11 split flag1", {15'h0, ct[3]}, 16'(s));
      reg_rd(8'h8B, lo); reg_rd(8'h8D, hi);
      chk("R11 channel 1 keeps counting", {hi, lo}, 16'h000A);
    end

    // R11: channel 1 parked in format 11, channel 0 unaffected
    reg_wr(MODE, 8'h31);
    reg_wr(CTRL, 8'h00);
    reg_wr(8'h8B, 8'h55); reg_wr(8'h8D, 8'h66);
    reg_wr(LO0, 8'h00); reg_wr(HI0, 8'h00);
    run_for(20, 8'h05);
    reg_rd(8'h8B, lo); reg_rd(8'h8D, hi); chk("R11 parked channel holds", {hi, lo}, 16'h6655);
    reg_rd(LO0, lo); chk("R11 channel 0 independent", {8'h0, lo}, 16'd20);
    reg_rd(CTRL, ct); chk("R11 parked no flag", {12'h0, ct[3:0]}, 16'h0000);

    // R12: flag stays until written to zero
    reg_wr(MODE, 8'h01);
    reg_wr(LO0, 8'hFE); reg_wr(HI0, 8'hFF);
    run_for(3, 8'h01);
    repeat (15) @(negedge clk);
    reg_rd(CTRL, ct); chk("R12 flag sticky", {12'h0, ct[3:0]}, 16'h0002);
    reg_wr(CTRL, 8'h00);
    reg_rd(CTRL, ct); chk("R12 flag cleared", {12'h0, ct[3:0]}, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule